// File: doc/BRIEF.md
# Serial Audio Codec Bridge

This block sits between a stereo serial audio codec and a memory-mapped processor bus. From the system clock it derives the three clocks the codec needs: a master clock, a serial bit clock and a left/right channel clock. A receive shift register collects the ADC bit stream into 16-bit samples. A transmit shift register sends 16-bit playback samples to the DAC. Two small FIFOs decouple the audio timing from the bus. The record FIFO holds captured samples until the processor reads them. The playback FIFO holds samples the processor has written until the codec consumes them.

Words move between the shift registers and the FIFOs only at channel-clock edges. Each edge closes one 16-bit slot for one channel. The processor reaches the block through a 64 KiB window with two decoded offsets. The data offset pops recorded samples on a read and queues playback samples on a write. The status offset reports whether a recorded sample is waiting and whether the playback queue has room, so software can poll before each data access. Each selected access is answered with a single-cycle acknowledge.

Top module: `aud_serial_bridge`

## Requirements
- R1: After reset the master, bit and channel clocks are low. The master clock toggles every MCLK_HALF system cycles. The bit clock first rises BCLK_HALF cycles after reset and then toggles every BCLK_HALF cycles.
- R2: The channel clock toggles only in the cycle where the bit clock falls, once every 16 bit periods (32*BCLK_HALF system cycles). Each toggle closes one 16-bit channel slot.
- R3: The DAC line changes only when the bit clock falls. It sends each word most significant bit first, one bit per bit-clock period. The word is loaded at a channel-clock toggle by popping the playback FIFO.
- R4: If the playback FIFO is empty at a channel-clock toggle, the next slot sends all zeros. The first slot after reset also sends all zeros.
- R5: The ADC line is sampled when the bit clock rises, most significant bit first. At each channel-clock toggle the 16 bits sampled in the slot just ended are pushed into the record FIFO (16 entries). The word is dropped if the FIFO is full.
- R6: An access is decoded only when select is high and address bits 31:16 equal 0xFEFE. Any other access gets no acknowledge.
- R7: A read at offset 0x0 pops the oldest recorded sample and returns it in bits 15:0, with the upper bits zero. A read of an empty record FIFO returns zero and pops nothing.
- R8: A write at offset 0x0 appends bits 15:0 to the playback FIFO (16 entries). The write is dropped when the FIFO is full.
- R9: A read at offset 0x4 returns bit 0 = record FIFO not empty and bit 1 = playback FIFO not full, with all other bits zero. Writes to 0x4, and any access to another offset, change no state; such reads return zero.
- R10: Each decoded access gets exactly one acknowledge. It is high for one cycle, starting the cycle after select is first seen. No further acknowledge follows until select has been low. Read data is zero whenever acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Bus slave select |
| bus_addr_i | input | ADDR_W (32) | Bus address |
| bus_rnw_i | input | 1 | 1 = read, 0 = write |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Single-cycle transfer acknowledge |
| codec_mclk_o | output | 1 | Codec master clock |
| codec_bclk_o | output | 1 | Serial bit clock |
| codec_lrclk_o | output | 1 | Left/right channel clock |
| adc_sdata_i | input | 1 | Serial sample data from the ADC |
| dac_sdata_o | output | 1 | Serial sample data to the DAC |

## Verification
A bad FIFO pointer or count shows up at the first data read or status read after it occurs. The popped sample, or the ready bits, differ from a queue model kept from the bus traffic and the ADC words the bench sends. A slip in the bit or slot counters shows within one channel slot (64 system cycles at default settings). The channel-clock interval, the bit-clock interval, or the 16-bit word caught from the DAC line then disagrees with the expected word. A stuck control state shows in the next access, as a missing or repeated acknowledge.

// File: rtl/aud_bridge_pkg.sv
package aud_bridge_pkg;

   typedef enum logic {
      BUS_IDLE = 1'b0,
      BUS_HOLD = 1'b1
   } bus_state_e;

   localparam int STAT_REC_AVAIL = 0;
   localparam int STAT_PB_ROOM   = 1;
   localparam int STAT_BITS      = 2;

endpackage

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
   parameter int MCLK_HALF = 1,
   parameter int BCLK_HALF = 2,
   parameter int SLOT_BITS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic mclk_o,
   output logic bclk_o,
   output logic lrclk_o,
   output logic bit_rise_o,
   output logic bit_fall_o,
   output logic slot_end_o
);

   localparam int BCW = (2 * BCLK_HALF > 2) ? $clog2(2 * BCLK_HALF) : 1;
   localparam int SCW = $clog2(SLOT_BITS);
   localparam logic [BCW-1:0] RISE_AT  = BCW'(BCLK_HALF - 1);
   localparam logic [BCW-1:0] FALL_AT  = BCW'(2 * BCLK_HALF - 1);
   localparam logic [SCW-1:0] LAST_BIT = SCW'(SLOT_BITS - 1);

   generate
      if (MCLK_HALF < 1) begin : g_bad_mclk
         $error("MCLK_HALF must be at least 1");
      end
      if (BCLK_HALF < 1) begin : g_bad_bclk
         $error("BCLK_HALF must be at least 1");
      end
      if (SLOT_BITS < 2) begin : g_bad_slot
         $error("SLOT_BITS must be at least 2");
      end
   endgenerate

   logic [BCW-1:0] bcnt_q;
   logic [SCW-1:0] bitcnt_q;
   logic           bclk_q;
   logic           lrclk_q;

   assign bit_rise_o = (bcnt_q == RISE_AT);
   assign bit_fall_o = (bcnt_q == FALL_AT);
   assign slot_end_o = bit_fall_o && (bitcnt_q == LAST_BIT);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         bcnt_q   <= '0;
         bitcnt_q <= '0;
         bclk_q   <= 1'b0;
         lrclk_q  <= 1'b0;
      end else begin
         bcnt_q <= bit_fall_o ? '0 : bcnt_q + 1'b1;
         if (bit_rise_o) begin
            bclk_q <= 1'b1;
         end else if (bit_fall_o) begin
            bclk_q <= 1'b0;
         end
         if (bit_fall_o) begin
            bitcnt_q <= (bitcnt_q == LAST_BIT) ? '0 : bitcnt_q + 1'b1;
         end
         if (slot_end_o) begin
            lrclk_q <= ~lrclk_q;
         end
      end
   end

   assign bclk_o  = bclk_q;
   assign lrclk_o = lrclk_q;

   generate
      if (MCLK_HALF == 1) begin : g_mclk_toggle
         logic mclk_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) mclk_q <= 1'b0;
            else         mclk_q <= ~mclk_q;
         end
         assign mclk_o = mclk_q;
      end else begin : g_mclk_count
         localparam int MCW = $clog2(MCLK_HALF);
         localparam logic [MCW-1:0] MC_LAST = MCW'(MCLK_HALF - 1);
         logic [MCW-1:0] mcnt_q;
         logic           mclk_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               mcnt_q <= '0;
               mclk_q <= 1'b0;
            end else if (mcnt_q == MC_LAST) begin
               mcnt_q <= '0;
               mclk_q <= ~mclk_q;
            end else begin
               mcnt_q <= mcnt_q + 1'b1;
            end
         end
         assign mclk_o = mclk_q;
      end
   endgenerate

   // R2: channel clock moves only together with a falling bit clock
   a_r2_lr_on_fall : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(lrclk_o) |-> $fell(bclk_o));

   // R1: bit clock moves only on a strobe of the counter
   a_r1_bclk_on_strobe : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(bclk_o) |-> $past(bit_rise_o || bit_fall_o));

endmodule

// File: rtl/aud_fifo.sv
module aud_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam int PW = $clog2(DEPTH);
   localparam logic [PW:0] DEPTH_C = (PW + 1)'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PW-1:0]    wr_ptr_q;
   logic [PW-1:0]    rd_ptr_q;
   logic [PW:0]      count_q;
   logic             push_ok;
   logic             pop_ok;

   assign empty_o = (count_q == '0);
   assign full_o  = (count_q == DEPTH_C);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign head_o  = mem_q[rd_ptr_q];

   always_ff @(posedge clk_i) begin
      if (push_ok) begin
         mem_q[wr_ptr_q] <= data_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   // R5, R8: occupancy never passes the depth
   a_r8_count_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= DEPTH_C);

   // R5, R8: a push into a full queue without a pop is dropped
   a_r5_full_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_ptr_q)));

   // R7: a pop of an empty queue leaves it untouched
   a_r7_empty_pop : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_ptr_q)));

endmodule

// File: rtl/aud_serdes.sv
module aud_serdes #(
   parameter int WIDTH     = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bit_rise_i,
   input  logic             bit_fall_i,
   input  logic             slot_end_i,
   input  logic             sdin_i,
   input  logic [WIDTH-1:0] tx_word_i,
   input  logic             tx_avail_i,
   output logic             sdout_o,
   output logic [WIDTH-1:0] rx_word_o,
   output logic             tx_pop_o,
   output logic             rx_push_o
);

   logic [WIDTH-1:0] rx_sr_q;
   logic [WIDTH-1:0] tx_sr_q;
   logic [WIDTH-1:0] rx_next;
   logic [WIDTH-1:0] tx_next;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign rx_next = {rx_sr_q[WIDTH-2:0], sdin_i};
         assign tx_next = {tx_sr_q[WIDTH-2:0], 1'b0};
         assign sdout_o = tx_sr_q[WIDTH-1];
      end else begin : g_lsb_first
         assign rx_next = {sdin_i, rx_sr_q[WIDTH-1:1]};
         assign tx_next = {1'b0, tx_sr_q[WIDTH-1:1]};
         assign sdout_o = tx_sr_q[0];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rx_sr_q <= '0;
         tx_sr_q <= '0;
      end else begin
         if (bit_rise_i) begin
            rx_sr_q <= rx_next;
         end
         if (slot_end_i) begin
            tx_sr_q <= tx_avail_i ? tx_word_i : '0;
         end else if (bit_fall_i) begin
            tx_sr_q <= tx_next;
         end
      end
   end

   assign rx_word_o = rx_sr_q;
   assign rx_push_o = slot_end_i;
   assign tx_pop_o  = slot_end_i && tx_avail_i;

   // R3: the DAC line holds between falling bit-clock strobes
   a_r3_sdout_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bit_fall_i |=> $stable(sdout_o));

   // R4: an empty playback queue at a slot boundary starts a silent slot
   a_r4_silent_slot : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_end_i && !tx_avail_i) |=> (tx_sr_q == '0));

endmodule

// File: rtl/aud_bus_ctrl.sv
module aud_bus_ctrl
   import aud_bridge_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter int                SAMPLE_W = 16,
   parameter int                DEC_W    = 16,
   parameter logic [DEC_W-1:0]  BASE_TAG = 16'hFEFE,
   parameter int                DATA_OFF = 0,
   parameter int                STAT_OFF = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sel_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                rnw_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [SAMPLE_W-1:0] rec_head_i,
   input  logic                rec_empty_i,
   input  logic                pb_full_i,
   output logic                rec_pop_o,
   output logic                pb_push_o,
   output logic [SAMPLE_W-1:0] pb_data_o,
   output logic                ack_o,
   output logic [DATA_W-1:0]   rdata_o
);

   localparam int OFF_W = ADDR_W - DEC_W;
   localparam logic [OFF_W-1:0] DATA_OFF_C = OFF_W'(DATA_OFF);
   localparam logic [OFF_W-1:0] STAT_OFF_C = OFF_W'(STAT_OFF);

   generate
      if (ADDR_W <= DEC_W) begin : g_bad_addr
         $error("ADDR_W must exceed DEC_W");
      end
      if (DATA_W < SAMPLE_W || DATA_W < STAT_BITS) begin : g_bad_data
         $error("DATA_W too narrow for samples or status");
      end
      if (DATA_W > SAMPLE_W) begin : g_fold_hi
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata_i[DATA_W-1:SAMPLE_W];
      end
   endgenerate

   bus_state_e          state_q;
   logic                hit;
   logic                start;
   logic                is_data;
   logic                is_stat;
   logic [DATA_W-1:0]   rd_value;
   logic [STAT_BITS-1:0] stat_bits;
   logic                ack_q;
   logic [DATA_W-1:0]   rdata_q;

   assign hit     = sel_i && (addr_i[ADDR_W-1:OFF_W] == BASE_TAG);
   assign start   = (state_q == BUS_IDLE) && hit;
   assign is_data = (addr_i[OFF_W-1:0] == DATA_OFF_C);
   assign is_stat = (addr_i[OFF_W-1:0] == STAT_OFF_C);

   always_comb begin
      stat_bits                 = '0;
      stat_bits[STAT_REC_AVAIL] = ~rec_empty_i;
      stat_bits[STAT_PB_ROOM]   = ~pb_full_i;
   end

   always_comb begin
      rd_value = '0;
      if (is_data && !rec_empty_i) begin
         rd_value = DATA_W'(rec_head_i);
      end else if (is_stat) begin
         rd_value = DATA_W'(stat_bits);
      end
   end

   assign rec_pop_o = start && rnw_i && is_data && !rec_empty_i;
   assign pb_push_o = start && !rnw_i && is_data;
   assign pb_data_o = wdata_i[SAMPLE_W-1:0];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= BUS_IDLE;
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= start;
         rdata_q <= (start && rnw_i) ? rd_value : '0;
         case (state_q)
            BUS_IDLE: if (start)  state_q <= BUS_HOLD;
            BUS_HOLD: if (!sel_i) state_q <= BUS_IDLE;
            default:              state_q <= BUS_IDLE;
         endcase
      end
   end

   assign ack_o   = ack_q;
   assign rdata_o = rdata_q;

   // R10: acknowledge is a one-cycle pulse
   a_r10_ack_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |=> !ack_o);

   // R6: acknowledge only follows a decoded select
   a_r6_ack_needs_hit : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> ($past(sel_i) && $past(addr_i[ADDR_W-1:OFF_W]) == BASE_TAG));

   // R7: read of an empty record queue answers zero
   a_r7_empty_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o && $past(rnw_i && is_data && rec_empty_i)) |-> (rdata_o == '0));

   // R9: status reads keep the unused bits clear
   a_r9_stat_upper : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o && $past(rnw_i && is_stat)) |-> (rdata_o[DATA_W-1:STAT_BITS] == '0));

   // R10: read data is zero outside acknowledge
   a_r10_rdata_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_o |-> (rdata_o == '0));

endmodule

// File: rtl/aud_serial_bridge.sv
module aud_serial_bridge #(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          SAMPLE_W   = 16,
   parameter int          FIFO_DEPTH = 16,
   parameter int          MCLK_HALF  = 1,
   parameter int          BCLK_HALF  = 2,
   parameter logic [15:0] BASE_TAG   = 16'hFEFE,
   parameter bit          MSB_FIRST  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_rnw_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              bus_ack_o,
   output logic              codec_mclk_o,
   output logic              codec_bclk_o,
   output logic              codec_lrclk_o,
   input  logic              adc_sdata_i,
   output logic              dac_sdata_o
);

   localparam int SLOT_BITS = SAMPLE_W;

   logic                bit_rise;
   logic                bit_fall;
   logic                slot_end;
   logic [SAMPLE_W-1:0] rx_word;
   logic                rx_push;
   logic [SAMPLE_W-1:0] rec_head;
   logic                rec_empty;
   logic                rec_full;
   logic                rec_pop;
   logic [SAMPLE_W-1:0] pb_head;
   logic                pb_empty;
   logic                pb_full;
   logic                pb_pop;
   logic                pb_push;
   logic [SAMPLE_W-1:0] pb_data;
   logic                unused_rec_full;

   assign unused_rec_full = rec_full;

   aud_clkgen #(
      .MCLK_HALF (MCLK_HALF),
      .BCLK_HALF (BCLK_HALF),
      .SLOT_BITS (SLOT_BITS)
   ) u_clkgen (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mclk_o     (codec_mclk_o),
      .bclk_o     (codec_bclk_o),
      .lrclk_o    (codec_lrclk_o),
      .bit_rise_o (bit_rise),
      .bit_fall_o (bit_fall),
      .slot_end_o (slot_end)
   );

   aud_serdes #(
      .WIDTH     (SAMPLE_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_serdes (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bit_rise_i (bit_rise),
      .bit_fall_i (bit_fall),
      .slot_end_i (slot_end),
      .sdin_i     (adc_sdata_i),
      .tx_word_i  (pb_head),
      .tx_avail_i (~pb_empty),
      .sdout_o    (dac_sdata_o),
      .rx_word_o  (rx_word),
      .tx_pop_o   (pb_pop),
      .rx_push_o  (rx_push)
   );

   aud_fifo #(
      .WIDTH (SAMPLE_W),
      .DEPTH (FIFO_DEPTH)
   ) u_rec_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (rx_push),
      .data_i  (rx_word),
      .pop_i   (rec_pop),
      .head_o  (rec_head),
      .empty_o (rec_empty),
      .full_o  (rec_full)
   );

   aud_fifo #(
      .WIDTH (SAMPLE_W),
      .DEPTH (FIFO_DEPTH)
   ) u_pb_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (pb_push),
      .data_i  (pb_data),
      .pop_i   (pb_pop),
      .head_o  (pb_head),
      .empty_o (pb_empty),
      .full_o  (pb_full)
   );

   aud_bus_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SAMPLE_W (SAMPLE_W),
      .DEC_W    (16),
      .BASE_TAG (BASE_TAG),
      .DATA_OFF (0),
      .STAT_OFF (4)
   ) u_bus_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (bus_sel_i),
      .addr_i      (bus_addr_i),
      .rnw_i       (bus_rnw_i),
      .wdata_i     (bus_wdata_i),
      .rec_head_i  (rec_head),
      .rec_empty_i (rec_empty),
      .pb_full_i   (pb_full),
      .rec_pop_o   (rec_pop),
      .pb_push_o   (pb_push),
      .pb_data_o   (pb_data),
      .ack_o       (bus_ack_o),
      .rdata_o     (bus_rdata_o)
   );

endmodule

// File: tb/aud_serial_bridge_bench.sv
`timescale 1ns/100ps
module aud_serial_bridge_bench;

   localparam int MH = 1;
   localparam int BH = 2;
   localparam int DEPTH = 16;
   localparam logic [31:0] DATA_A = 32'hFEFE_0000;
   localparam logic [31:0] STAT_A = 32'hFEFE_0004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic [31:0] addr = '0;
   logic        rnw = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ack;
   logic        mclk, bclk, lrclk;
   logic        sdin = 1'b0;
   logic        sdout;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   aud_serial_bridge u_aud_serial_bridge (
      .clk_i (clk), .rst_ni (rst_n), .bus_sel_i (sel), .bus_addr_i (addr),
      .bus_rnw_i (rnw), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
      .bus_ack_o (ack), .codec_mclk_o (mclk), .codec_bclk_o (bclk),
      .codec_lrclk_o (lrclk), .adc_sdata_i (sdin), .dac_sdata_o (sdout)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] stat_word(input int rec_n, input int pb_n);
      return {30'd0, pb_n < DEPTH, rec_n > 0};
   endfunction

   // reference model of both queues and of the serial lines
   logic [15:0] rec_q[$];
   logic [15:0] pb_q[$];
   logic [15:0] cur_rx, exp_tx, tx_bits, got;
   int          rx_idx, rises, cyc_m, cyc_b, cyc_l, rec_pre, pb_pre;
   logic        pm, pbk, pl;
   logic [31:0] expv;

   always @(posedge clk) begin
      #1;
      if (!rst_n) begin
         rec_q.delete(); pb_q.delete();
         cur_rx = 16'($urandom); rx_idx = 15; sdin = cur_rx[15];
         exp_tx = '0; tx_bits = '0; rises = 0;
         cyc_m = 0; cyc_b = 0; cyc_l = 0; pm = 0; pbk = 0; pl = 0;
      end else begin
         cyc_m++; cyc_b++; cyc_l++;
         if (mclk != pm) begin
            check(cyc_m == MH, "R1 master clock half period", cyc_m, MH);
            cyc_m = 0;
         end
         if (bclk != pbk) begin
            check(cyc_b == BH, "R1 bit clock half period", cyc_b, BH);
            cyc_b = 0;
         end
         rec_pre = rec_q.size();
         pb_pre  = pb_q.size();
         if (ack) begin
            if (rnw) begin
               expv = '0;
               if (addr[15:0] == 16'h0000) begin
                  if (rec_pre > 0) expv = {16'd0, rec_q.pop_front()};
                  check(rdata == expv, "R7 data read", rdata, expv);
               end else if (addr[15:0] == 16'h0004) begin
                  expv = stat_word(rec_pre, pb_pre);
                  check(rdata == expv, "R9 status read", rdata, expv);
               end else begin
                  check(rdata == expv, "R9 other offset reads zero", rdata, expv);
               end
            end else if (addr[15:0] == 16'h0000 && pb_pre < DEPTH) begin
               pb_q.push_back(wdata[15:0]);   // R8 accepted write
            end
         end else begin
            check(rdata == '0, "R10 rdata zero without ack", rdata, 0);
         end
         if (lrclk != pl) begin
            check(bclk == 1'b0 && pbk == 1'b1, "R2 channel edge with bit fall", {31'd0, bclk}, 0);
            check(cyc_l == 32 * BH, "R2 slot length", cyc_l, 32 * BH);
            cyc_l = 0;
            check(rises == 16, "R3 bits per slot", rises, 16);
            check(tx_bits == exp_tx, "R3 R4 DAC word", {16'd0, tx_bits}, {16'd0, exp_tx});
            exp_tx = (pb_pre > 0) ? pb_q.pop_front() : 16'h0000;
            tx_bits = '0; rises = 0;
            if (rec_pre < DEPTH) rec_q.push_back(cur_rx);   // R5 capture or drop
            cur_rx = 16'($urandom); rx_idx = 15; sdin = cur_rx[15];
         end else if (!bclk && pbk) begin
            rx_idx--; sdin = cur_rx[rx_idx];
         end
         if (bclk && !pbk) begin
            tx_bits = {tx_bits[14:0], sdout};
            rises++;
         end
         pm = mclk; pbk = bclk; pl = lrclk;
      end
   end

   task automatic access(input logic [31:0] a, input logic r, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; addr = a; rnw = r; wdata = d;
      @(negedge clk);
      check(ack == 1'b1, "R10 ack one cycle after select", {31'd0, ack}, 1);
      sel = 1'b0;
      @(negedge clk);
      check(ack == 1'b0, "R10 ack single cycle", {31'd0, ack}, 0);
   endtask

   task automatic no_hit(input logic [31:0] a, input logic s);
      @(negedge clk);
      sel = s; addr = a; rnw = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(ack == 1'b0, "R6 no ack without decode", {31'd0, ack}, 0);
      end
      sel = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      check({mclk, bclk, lrclk, sdout, ack} == 5'b0, "R1 R2 R10 reset outputs",
            {27'd0, mclk, bclk, lrclk, sdout, ack}, 0);
      check(rdata == '0, "R10 reset rdata", rdata, 0);
      rst_n = 1'b1;
      // R7 empty read before the first slot closes, then status
      access(DATA_A, 1'b1, 0);
      access(STAT_A, 1'b1, 0);
      // R6 decode misses
      no_hit(32'hFEFF_0000, 1'b1);
      no_hit(32'h0EFE_0004, 1'b1);
      no_hit(DATA_A, 1'b0);
      // R10 select held long: one ack only
      @(negedge clk);
      sel = 1'b1; addr = STAT_A; rnw = 1'b1;
      @(negedge clk);
      check(ack == 1'b1, "R10 ack on held select", {31'd0, ack}, 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(ack == 1'b0, "R10 no repeat ack on held select", {31'd0, ack}, 0);
      end
      sel = 1'b0;
      // R8 overfill playback queue, R9 writes to status and other offsets ignored
      for (int i = 0; i < 20; i++) access(DATA_A, 1'b0, 32'hABC0_0000 | 32'(i * 4099));
      access(STAT_A, 1'b1, 0);
      access(STAT_A, 1'b0, 32'hFFFF_FFFF);
      access(32'hFEFE_0008, 1'b0, 32'h1234_5678);
      access(32'hFEFE_0008, 1'b1, 0);
      // R5 let the record queue overflow, then drain past empty
      repeat (24 * 32 * BH) @(negedge clk);
      access(STAT_A, 1'b1, 0);
      for (int i = 0; i < 20; i++) access(DATA_A, 1'b1, 0);
      // mixed random traffic
      for (int n = 0; n < 1500; n++) begin
         case ($urandom % 8)
            0, 1, 2: access(DATA_A, 1'b1, 0);
            3, 4:    access(DATA_A, 1'b0, $urandom);
            5:       access(STAT_A, 1'b1, 0);
            6:       access((($urandom % 2) == 0) ? STAT_A : 32'hFEFE_0010, $urandom % 2, $urandom);
            default: repeat ($urandom % 40) @(negedge clk);
         endcase
      end
      repeat (40 * 32 * BH) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL R10 watchdog: actual still running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule